// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings one or more DDR SDRAM slots from power-on to a state where normal traffic may begin. After a start request it captures which slots are fitted and the two mode-register words to program, waits for the clocks to settle, raises clock-enable on the fitted slots and then drives a fixed command stream onto a single-cycle command interface. The stream is a precharge of all banks, the extended mode word with the DLL turned on, the base mode word with DLL reset asserted, a long DLL settling pause, a second precharge of all banks, two auto-refresh commands and the base mode word again with DLL reset released.

Spacing between commands is set by parameters for precharge recovery, mode-register programming and refresh recovery. When the last spacing has run out, a completion flag rises and stays high. If no slot is fitted, the block raises an error flag instead and issues nothing. The SDRAM clock of every slot that is not fitted is switched off when the start request is accepted.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is held and just after it is released, no command is issued (cmd_valid_o low and cmd_code_o is NOP = 0), every cke_o bit is low, every slot_clk_en_o bit is high, and done_o and err_o are low.
- R2: start_i is only acted on while the block is idle. When it is accepted, slot_present_i, emr_word_i and mr_word_i are captured. A start request during the sequence or after completion changes no output and adds no command.
- R3: If start_i is accepted while no slot_present_i bit is set, err_o is high from the cycle after acceptance and stays high. No command is ever issued, cke_o stays all low and slot_clk_en_o goes all low.
- R4: cke_o stays low for STABLE_US*CLK_MHZ+1 clock cycles (a stable-clock wait of more than STABLE_US microseconds) counted from the acceptance edge. The first command comes exactly one cycle after cke_o rises.
- R5: Command codes are NOP = 0, precharge-all = 1, load-mode = 2 and refresh = 3. The seven commands come in this order: (1) precharge-all with address bit AP_BIT set and bank 0; (2) load-mode to bank 1 carrying the captured extended word with bit DLL_DIS_BIT cleared; (3) load-mode to bank 0 carrying the captured base word with bit DLL_RST_BIT set; (4) precharge-all; (5) refresh; (6) refresh; (7) load-mode to bank 0 carrying the base word with bit DLL_RST_BIT cleared. Refresh commands carry bank 0 and address 0.
- R6: Each precharge-all is followed by the next command exactly T_RP cycles later.
- R7: The extended load-mode is followed by the next command exactly T_MRD cycles later. The DLL-reset load-mode is followed by the next command exactly max(DLL_WAIT_CLKS, T_MRD) cycles later, which is at least 200 cycles by default.
- R8: Each refresh is followed by the next command exactly T_RFC cycles later.
- R9: done_o rises exactly T_MRD cycles after the final load-mode command. It then stays high until reset, and no further command is issued.
- R10: From one cycle before the first command, cke_o is high for exactly the fitted slots and stays so. Every command is issued with at least one cke_o bit high.
- R11: From the cycle after acceptance, slot_clk_en_o equals the captured fitted-slot mask, so the clock of an empty slot is gated off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run the power-up sequence |
| slot_present_i | input | NSLOT | One bit per slot, set when the slot is fitted |
| emr_word_i | input | ADDR_W | Extended mode word to program |
| mr_word_i | input | ADDR_W | Base mode word to program |
| cmd_valid_o | output | 1 | A command is on the interface this cycle |
| cmd_code_o | output | 2 | Command code: 0 NOP, 1 precharge-all, 2 load-mode, 3 refresh |
| cmd_bank_o | output | 2 | Bank select for the command |
| cmd_addr_o | output | ADDR_W | Address or mode word for the command |
| cke_o | output | NSLOT | Per-slot clock enable to the SDRAM |
| slot_clk_en_o | output | NSLOT | Per-slot SDRAM clock gate enable |
| done_o | output | 1 | Sequence complete, normal operation may start |
| err_o | output | 1 | Start accepted with no slot fitted |

## Verification
On every cycle the assertions check that done and error are sticky and mutually exclusive and that neither state issues commands. They also check that commands are never back to back, that a command always has a clock-enable high, and that clock-enable is only raised on clocked slots and never drops once raised. The exact command order and payloads, the spacing counts, the stable-clock wait, the mode-word bit manipulation and the capture of inputs at start are shown only by the bench's scenarios. A scoreboard checks each command and its distance from the previous one across fully fitted, partly fitted and empty configurations, with late start requests included.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP       = 2'd0,
    CMD_PRE_ALL   = 2'd1,
    CMD_LOAD_MODE = 2'd2,
    CMD_REFRESH   = 2'd3
  } ddr_cmd_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_STABLE, ST_CKE,
    ST_PRE1, ST_W_PRE1, ST_EMRS, ST_W_EMRS,
    ST_MRS_RST, ST_W_DLL, ST_PRE2, ST_W_PRE2,
    ST_REF1, ST_W_REF1, ST_REF2, ST_W_REF2,
    ST_MRS_CLR, ST_W_MRS, ST_DONE, ST_ERR
  } init_st_e;

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] count_q, count_d;

  assign expired_o = (count_q == '0);

  always_comb begin
    count_d = count_q;
    if (load_i)          count_d = load_val_i;
    else if (!expired_o) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm import ddr_init_pkg::*; #(
  parameter int STABLE_CLKS = 10001,
  parameter int DLL_GAP     = 200,
  parameter int T_RP        = 3,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     any_present_i,
  output init_st_e state_o,
  output logic     capture_o,
  output logic     cke_set_o
);

  localparam int MAX_A = (STABLE_CLKS > DLL_GAP) ? STABLE_CLKS : DLL_GAP;
  localparam int MAX_B = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAX_V = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_V + 1);

  init_st_e      state_q, state_d;
  logic          ld;
  logic [TW-1:0] ld_val;
  logic          expired;

  ddr_gap_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld),
    .load_val_i (ld_val),
    .expired_o  (expired)
  );

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && start_i;
  assign cke_set_o = (state_q == ST_STABLE) && expired;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (any_present_i) begin
          state_d = ST_STABLE;
          ld      = 1'b1;
          ld_val  = TW'(STABLE_CLKS - 1);
        end else begin
          state_d = ST_ERR;
        end
      end
      ST_STABLE:  if (expired) state_d = ST_CKE;
      ST_CKE:     state_d = ST_PRE1;
      ST_PRE1:    begin state_d = ST_W_PRE1; ld = 1'b1; ld_val = TW'(T_RP - 2); end
      ST_W_PRE1:  if (expired) state_d = ST_EMRS;
      ST_EMRS:    begin state_d = ST_W_EMRS; ld = 1'b1; ld_val = TW'(T_MRD - 2); end
      ST_W_EMRS:  if (expired) state_d = ST_MRS_RST;
      ST_MRS_RST: begin state_d = ST_W_DLL; ld = 1'b1; ld_val = TW'(DLL_GAP - 2); end
      ST_W_DLL:   if (expired) state_d = ST_PRE2;
      ST_PRE2:    begin state_d = ST_W_PRE2; ld = 1'b1; ld_val = TW'(T_RP - 2); end
      ST_W_PRE2:  if (expired) state_d = ST_REF1;
      ST_REF1:    begin state_d = ST_W_REF1; ld = 1'b1; ld_val = TW'(T_RFC - 2); end
      ST_W_REF1:  if (expired) state_d = ST_REF2;
      ST_REF2:    begin state_d = ST_W_REF2; ld = 1'b1; ld_val = TW'(T_RFC - 2); end
      ST_W_REF2:  if (expired) state_d = ST_MRS_CLR;
      ST_MRS_CLR: begin state_d = ST_W_MRS; ld = 1'b1; ld_val = TW'(T_MRD - 2); end
      ST_W_MRS:   if (expired) state_d = ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      ST_ERR:     state_d = ST_ERR;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ddr_cmd_enc.sv
module ddr_cmd_enc import ddr_init_pkg::*; #(
  parameter int ADDR_W      = 13,
  parameter int DLL_RST_BIT = 8,
  parameter int AP_BIT      = 10,
  parameter int DLL_DIS_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] emr_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  init_st_e          state_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_code_o,
  output logic [1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);

  localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] DIS_MASK = ADDR_W'(1) << DLL_DIS_BIT;

  logic [ADDR_W-1:0] emr_q, mr_q;
  ddr_cmd_e          code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emr_q <= '0;
      mr_q  <= '0;
    end else if (capture_i) begin
      emr_q <= emr_i;
      mr_q  <= mr_i;
    end
  end

  always_comb begin
    code       = CMD_NOP;
    cmd_bank_o = 2'd0;
    cmd_addr_o = '0;
    unique case (state_i)
      ST_PRE1, ST_PRE2: begin
        code       = CMD_PRE_ALL;
        cmd_addr_o = AP_MASK;
      end
      ST_EMRS: begin
        code       = CMD_LOAD_MODE;
        cmd_bank_o = 2'd1;
        cmd_addr_o = emr_q & ~DIS_MASK;
      end
      ST_MRS_RST: begin
        code       = CMD_LOAD_MODE;
        cmd_addr_o = mr_q | RST_MASK;
      end
      ST_MRS_CLR: begin
        code       = CMD_LOAD_MODE;
        cmd_addr_o = mr_q & ~RST_MASK;
      end
      ST_REF1, ST_REF2: code = CMD_REFRESH;
      default: code = CMD_NOP;
    endcase
  end

  assign cmd_code_o  = code;
  assign cmd_valid_o = (code != CMD_NOP);

endmodule

// File: rtl/ddr_slot_gate.sv
module ddr_slot_gate #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             cke_set_i,
  input  logic [NSLOT-1:0] present_i,
  output logic             any_present_o,
  output logic [NSLOT-1:0] cke_o,
  output logic [NSLOT-1:0] clk_en_o
);

  assign any_present_o = |present_i;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic clk_en_q, cke_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         clk_en_q <= 1'b1;
      else if (capture_i) clk_en_q <= present_i[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cke_q <= 1'b0;
      else if (cke_set_i) cke_q <= clk_en_q;
    end

    assign clk_en_o[s] = clk_en_q;
    assign cke_o[s]    = cke_q;
  end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq import ddr_init_pkg::*; #(
  parameter int NSLOT         = 2,
  parameter int ADDR_W        = 13,
  parameter int CLK_MHZ       = 50,
  parameter int STABLE_US     = 200,
  parameter int DLL_WAIT_CLKS = 200,
  parameter int T_RP          = 3,
  parameter int T_MRD         = 2,
  parameter int T_RFC         = 8,
  parameter int DLL_RST_BIT   = 8,
  parameter int AP_BIT        = 10,
  parameter int DLL_DIS_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NSLOT-1:0]  slot_present_i,
  input  logic [ADDR_W-1:0] emr_word_i,
  input  logic [ADDR_W-1:0] mr_word_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_code_o,
  output logic [1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [NSLOT-1:0]  cke_o,
  output logic [NSLOT-1:0]  slot_clk_en_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int STABLE_CLKS = STABLE_US * CLK_MHZ + 1;
  localparam int DLL_GAP     = (DLL_WAIT_CLKS > T_MRD) ? DLL_WAIT_CLKS : T_MRD;

  init_st_e state;
  logic     capture, cke_set, any_present;

  ddr_init_fsm #(
    .STABLE_CLKS (STABLE_CLKS),
    .DLL_GAP     (DLL_GAP),
    .T_RP        (T_RP),
    .T_MRD       (T_MRD),
    .T_RFC       (T_RFC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .any_present_i (any_present),
    .state_o       (state),
    .capture_o     (capture),
    .cke_set_o     (cke_set)
  );

  ddr_cmd_enc #(
    .ADDR_W      (ADDR_W),
    .DLL_RST_BIT (DLL_RST_BIT),
    .AP_BIT      (AP_BIT),
    .DLL_DIS_BIT (DLL_DIS_BIT)
  ) u_enc (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (capture),
    .emr_i       (emr_word_i),
    .mr_i        (mr_word_i),
    .state_i     (state),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_addr_o  (cmd_addr_o)
  );

  ddr_slot_gate #(.NSLOT(NSLOT)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .capture_i     (capture),
    .cke_set_i     (cke_set),
    .present_i     (slot_present_i),
    .any_present_o (any_present),
    .cke_o         (cke_o),
    .clk_en_o      (slot_clk_en_o)
  );

  assign done_o = (state == ST_DONE);
  assign err_o  = (state == ST_ERR);

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_code_o,
  input logic [NSLOT-1:0] cke_o,
  input logic [NSLOT-1:0] slot_clk_en_o,
  input logic             done_o,
  input logic             err_o
);

  // R1 / R5: an idle interface shows the NOP code
  a_r5_idle_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> cmd_code_o == 2'd0);

  // R6, R7, R8: every spacing is at least two cycles
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  a_r10_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cke_o != '0);

  a_r10_cke_on_clocked_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o & ~slot_clk_en_o) == '0);

  a_r10_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o != '0) |=> $stable(cke_o));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o && !err_o);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !cmd_valid_o && cke_o == '0);

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(.NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_code_o    (cmd_code_o),
  .cke_o         (cke_o),
  .slot_clk_en_o (slot_clk_en_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/sim_ddr_pwrup_seq.sv
module sim_ddr_pwrup_seq;

  localparam int NSLOT    = 2;
  localparam int AW       = 13;
  localparam int STABLE   = 200 * 50 + 1;
  localparam int DLLGAP   = 200;
  localparam int TRP      = 3;
  localparam int TMRD     = 2;
  localparam int TRFC     = 8;
  localparam logic [AW-1:0] AP  = 13'h0400;
  localparam logic [AW-1:0] RST = 13'h0100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [NSLOT-1:0] present = '0;
  logic [AW-1:0]    emr = '0, mr = '0;
  logic             cmd_valid, done, err;
  logic [1:0]       cmd_code, cmd_bank;
  logic [AW-1:0]    cmd_addr;
  logic [NSLOT-1:0] cke, clk_en;

  always #10 clk = ~clk;

  ddr_pwrup_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .slot_present_i(present),
    .emr_word_i(emr), .mr_word_i(mr), .cmd_valid_o(cmd_valid),
    .cmd_code_o(cmd_code), .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
    .cke_o(cke), .slot_clk_en_o(clk_en), .done_o(done), .err_o(err)
  );

  typedef struct {
    logic [1:0]    code;
    logic [1:0]    bank;
    logic [AW-1:0] addr;
    int            gap;
    string         req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0, n_cmd = 0, last_cmd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops the expected command and compares payload and spacing
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && cmd_valid) begin
      n_cmd++;
      if (q.size() == 0) begin
        check("R2 unexpected command", 1, 0);
      end else begin
        e = q.pop_front();
        check({e.req, " code"}, cmd_code, e.code);
        check({e.req, " bank"}, cmd_bank, e.bank);
        check({e.req, " addr"}, cmd_addr, e.addr);
        check({e.req, " spacing"}, cyc - last_cmd, e.gap);
      end
      last_cmd = cyc;
    end
  end

  task automatic push(input logic [1:0] c, input logic [1:0] b, input logic [AW-1:0] a,
                      input int g, input string r);
    exp_t e;
    e.code = c; e.bank = b; e.addr = a; e.gap = g; e.req = r;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_cmd = 0;
    @(negedge clk);
    check("R1 valid", cmd_valid, 0);
    check("R1 code NOP", cmd_code, 0);
    check("R1 cke", cke, 0);
    check("R1 slot clocks", clk_en, 2'b11);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
  endtask

  task automatic run_seq(input logic [NSLOT-1:0] pm, input logic [AW-1:0] ew,
                         input logic [AW-1:0] mw);
    int acc;
    push(2'd1, 2'd0, AP,         STABLE + 1, "R4 R5 first precharge");
    push(2'd2, 2'd1, ew & ~13'h1, TRP,       "R6 R5 extended mode");
    push(2'd2, 2'd0, mw | RST,    TMRD,      "R7 R5 dll reset mode");
    push(2'd1, 2'd0, AP,          DLLGAP,    "R7 R5 second precharge");
    push(2'd3, 2'd0, '0,          TRP,       "R6 R5 refresh one");
    push(2'd3, 2'd0, '0,          TRFC,      "R8 R5 refresh two");
    push(2'd2, 2'd0, mw & ~RST,   TRFC,      "R8 R5 dll clear mode");
    @(negedge clk);
    start = 1'b1; present = pm; emr = ew; mr = mw;
    acc = cyc + 1;
    last_cmd = acc;
    @(negedge clk);
    start = 1'b0; present = ~pm; emr = 13'h1FFF; mr = 13'h0AAA;
    check("R11 slot clocks follow fitted mask", clk_en, pm);
    while (cyc < acc + STABLE - 1) @(negedge clk);
    check("R4 cke low during stable wait", cke, 0);
    check("R4 no command during stable wait", n_cmd, 0);
    @(negedge clk);
    check("R10 cke on fitted slots", cke, pm);
    while (cyc < acc + STABLE + 20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < acc + STABLE + 2000) @(negedge clk);
    check("R9 done raised", done, 1);
    check("R9 done timing", cyc - last_cmd, TMRD);
    check("R5 all commands issued", q.size(), 0);
    check("R2 late start kept fitted mask", clk_en, pm);
    check("R10 cke held", cke, pm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check("R2 start after done adds nothing", n_cmd, 7);
    check("R9 done stays high", done, 1);
    check("R9 no error", err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1, 0);
    report();
  end

  initial begin
    do_reset();
    run_seq(2'b11, 13'h0043, 13'h0062);
    do_reset();
    run_seq(2'b01, 13'h0002, 13'h0152);
    do_reset();
    begin
      int acc;
      @(negedge clk);
      start = 1'b1; present = 2'b00;
      acc = cyc + 1;
      @(negedge clk);
      start = 1'b0; present = 2'b11;
      check("R3 error raised", err, 1);
      check("R3 slot clocks off", clk_en, 2'b00);
      while (cyc < acc + STABLE + 300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      check("R3 no command issued", n_cmd, 0);
      check("R3 cke low", cke, 0);
      check("R3 error held", err, 1);
      check("R3 no done", done, 0);
    end
    report();
  end

endmodule